// File: doc/BRIEF.md
# Sequenced 16x16 Signed Multiplier

This block forms the 32-bit two's-complement product of two 16-bit signed operands using a single byte-wide multiplier that is reused for four steps. The byte multiplier can treat its inputs as unsigned × unsigned, signed × signed, or signed × unsigned. A controller runs the four byte products in a fixed order and folds each one into a 32-bit accumulator.

The order of steps is fixed. The high bytes are multiplied signed × signed and written straight into the upper half. The low bytes are multiplied unsigned and written straight into the lower half. Then come two cross terms: the high byte of A (signed) × the low byte of B (unsigned), and the high byte of B (signed) × the low byte of A (unsigned). Each cross term is added at byte offset 1. Because it is signed, the top bit of each cross term is first subtracted from the top result byte, which sign-extends the cross term into that byte.

A caller pulses `start` while the block is idle and then waits for `done`. The block holds the product until a new operation begins to overwrite it.

Top module: `smul16_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` seen high at a rising edge while `busy` is 0 captures `op_a` and `op_b` and raises `busy` from the following cycle.
- R3: When `done` is 1, `product` equals the signed 32-bit product of the two captured 16-bit two's-complement operands.
- R4: `done` is high for exactly one cycle. That cycle is the 13th cycle after the launching edge: two multiply cycles plus one accumulate cycle for each of four steps, then one done cycle. `busy` is high from cycle 1 through cycle 13 and low afterwards.
- R5: A `start` pulse while `busy` is 1 (including the done cycle) is ignored. It changes neither the latency nor the result.
- R6: While `busy` is 0, `product` keeps its value whatever `op_a`, `op_b` do.
- R7: The sign corrections of the cross terms give exact results at the extremes: 0x8000×0x8000 = 0x40000000, 0xFFFF×0xFFFF = 0x00000001, 0x7FFF×0x8000 = 0xC0008000.
- R8: Changes on `op_a` and `op_b` after the launching edge have no effect on the product of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, honoured only while idle |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 32 | Signed 32-bit product, held while idle |

## Verification
Several properties are checked on every cycle: the exact 13-cycle launch-to-done latency, the single-cycle done pulse, the value of the product when done fires (against operands the checker captures at launch), and the stability of the product while idle. Only the bench scenarios can show that the sign corrections are right across the whole operand space. The bench does this with a full cross product of corner values plus a pseudo-random sweep. The bench scenarios also inject start pulses and operand changes in the middle of an operation to show they are ignored.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MLOAD,
    ST_MWAIT,
    ST_ACC,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    MD_UU,
    MD_SS,
    MD_SU
  } mul_mode_t;

  localparam int unsigned NUM_STEPS = 4;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);
endpackage

// File: rtl/smul_bytemul.sv
module smul_bytemul
  import smul_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [W-1:0]    x,
  input  logic [W-1:0]    y,
  input  mul_mode_t       mode,
  output logic [2*W-1:0]  prod
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0]      x_q, y_q;
  mul_mode_t         mode_q;
  logic signed [W:0] xe, ye;
  logic signed [2*W+1:0] full;

  // stage 1: operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      y_q    <= '0;
      mode_q <= MD_UU;
    end else if (ld) begin
      x_q    <= x;
      y_q    <= y;
      mode_q <= mode;
    end
  end

  // sign extension by mode: x signed unless UU, y signed only for SS
  always_comb begin
    xe   = $signed({(mode_q != MD_UU) & x_q[W-1], x_q});
    ye   = $signed({(mode_q == MD_SS) & y_q[W-1], y_q});
    full = xe * ye;
  end

  // stage 2: product register
  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= full[PW-1:0];
  end
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output seq_state_t        state,
  output logic [STEP_W-1:0] step,
  output logic              launch,
  output logic              busy,
  output logic              done
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

  assign launch = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_MLOAD;
          step  <= '0;
          busy  <= 1'b1;
        end
        ST_MLOAD: state <= ST_MWAIT;
        ST_MWAIT: state <= ST_ACC;
        ST_ACC: begin
          if (step == LAST) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end else begin
            state <= ST_MLOAD;
            step  <= step + 1'b1;
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smul_accum.sv
module smul_accum
  import smul_pkg::*;
#(
  parameter int unsigned H = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [STEP_W-1:0] step,
  input  logic [2*H-1:0]    part,
  output logic [4*H-1:0]    acc
);
  localparam int unsigned AW = 4 * H;
  localparam int unsigned PW = 2 * H;

  logic [AW-1:0] cross_term, sign_fix;

  // cross term sits at byte offset 1; its sign bit is removed from the top byte
  assign cross_term = {{H{1'b0}}, part, {H{1'b0}}};
  assign sign_fix   = {{(H-1){1'b0}}, part[PW-1], {(3*H){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (en) begin
      unique case (step)
        STEP_W'(0): acc <= {part, {PW{1'b0}}};
        STEP_W'(1): acc <= {acc[AW-1:PW], part};
        default:    acc <= acc - sign_fix + cross_term;
      endcase
    end
  end
endmodule

// File: rtl/smul16_seq.sv
module smul16_seq
  import smul_pkg::*;
#(
  parameter int unsigned OP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic              busy,
  output logic              done,
  output logic [2*OP_W-1:0] product
);
  localparam int unsigned H = OP_W / 2;

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic              launch;
  logic [OP_W-1:0]   a_q, b_q;
  logic [H-1:0]      mx, my;
  mul_mode_t         mmode;
  logic [OP_W-1:0]   part;

  smul_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .state(state), .step(step), .launch(launch),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (launch) begin
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  // byte selection per step: hi*hi, lo*lo, Ahi*Blo, Bhi*Alo
  always_comb begin
    unique case (step)
      STEP_W'(0): begin mx = a_q[OP_W-1:H]; my = b_q[OP_W-1:H]; mmode = MD_SS; end
      STEP_W'(1): begin mx = a_q[H-1:0];    my = b_q[H-1:0];    mmode = MD_UU; end
      STEP_W'(2): begin mx = a_q[OP_W-1:H]; my = b_q[H-1:0];    mmode = MD_SU; end
      default:    begin mx = b_q[OP_W-1:H]; my = a_q[H-1:0];    mmode = MD_SU; end
    endcase
  end

  smul_bytemul #(.W(H)) u_mul (
    .clk(clk), .rst(rst), .ld(state == ST_MLOAD),
    .x(mx), .y(my), .mode(mmode), .prod(part)
  );

  smul_accum #(.H(H)) u_acc (
    .clk(clk), .rst(rst), .en(state == ST_ACC),
    .step(step), .part(part), .acc(product)
  );
endmodule

// File: rtl/smul16_seq_chk.sv
module smul16_seq_chk #(
  parameter int unsigned OP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic              busy,
  input logic              done,
  input logic [2*OP_W-1:0] product
);
  logic [4:0]                cnt;
  logic signed [OP_W-1:0]    ca, cb;
  logic signed [2*OP_W-1:0]  ref_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ca  <= '0;
      cb  <= '0;
    end else begin
      cnt <= busy ? cnt + 1'b1 : '0;
      if (!busy && start) begin
        ca <= op_a;
        cb <= op_b;
      end
    end
  end

  assign ref_p = ca * cb;

  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
  p_product_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == ref_p));
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt == 5'd12));
  p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
  p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt < 5'd12) |=> busy);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(product));
  p_done_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
endmodule

bind smul16_seq smul16_seq_chk #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
  .busy(busy), .done(done), .product(product)
);

// File: tb/sim_smul16_seq.sv
module sim_smul16_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        busy, done;
  logic [31:0] product;

  int vectors = 0;
  int errors  = 0;
  bit ended   = 1'b0;

  always #10 clk = ~clk;

  smul16_seq u0 (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // run one operation; disturb injects a start and new operands mid-run
  task automatic run(input logic [15:0] a, input logic [15:0] b, input bit disturb, input string req);
    logic signed [15:0] sa, sb;
    logic signed [31:0] exp;
    logic [31:0] held;
    int n;
    sa = a; sb = b;
    exp = sa * sb;
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    check("R2 busy after launch", 32'(busy), 32'd1);
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
      if (disturb && n == 5) begin
        start = 1'b1; op_a = ~a; op_b = a ^ b ^ 16'h5a5a;
      end else if (disturb && n == 6) begin
        start = 1'b0;
      end
      if (disturb && n == 13) start = 1'b1;
    end
    check(disturb ? "R5 latency with mid-run start" : "R4 latency", 32'(n), 32'd13);
    check(disturb ? "R8 product after operand change" : req, product, exp);
    @(negedge clk);
    start = 1'b0;
    check("R4 single done pulse", {30'd0, done, busy}, 32'd0);
    held = product;
    op_a = 16'h1234 ^ a; op_b = 16'hedcb ^ b;
    repeat (2) @(negedge clk);
    check("R6 product held while idle", product, held);
  endtask

  function automatic logic [15:0] corner(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'hffff;
      3: return 16'h7fff;  4: return 16'h8000;  5: return 16'h8001;
      6: return 16'h00ff;  7: return 16'hff00;  8: return 16'h0080;
      9: return 16'h7f80;  10: return 16'h0100; default: return 16'hff7f;
    endcase
  endfunction

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    check("R1 reset state", {done, busy, 30'd0} | product, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first idle cycle", {done, busy, 30'd0} | product, 32'd0);

    run(16'h8000, 16'h8000, 1'b0, "R7 min*min");
    check("R7 min*min value", product, 32'h40000000);
    run(16'hffff, 16'hffff, 1'b0, "R7 -1*-1");
    check("R7 -1*-1 value", product, 32'h00000001);
    run(16'h7fff, 16'h8000, 1'b0, "R7 max*min");
    check("R7 max*min value", product, 32'hc0008000);

    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        run(corner(i), corner(j), 1'b0, "R3 corner product");

    lfsr = 32'hace1_2357;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run(lfsr[31:16], lfsr[15:0], (k % 5) == 0, "R3 random product");
    end

    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule